// File: doc/BRIEF.md
# Snooping Coprocessor Mailbox

The block listens to every transaction on a simplified shared processor bus and claims only those that land in one 4 KB communication page, whose upper address bits are given on the `page_base` input. A host write to that page is the call: the 12-bit page offset of the write address is the argument word, and the bus data is not used. On every such write the block captures the argument and computes its placeholder function straight away. That function is a latency lookup: a 16-entry table indexed by the low four argument bits, plus the upper eight argument bits. The result is held in a register until the next write replaces it.

A host read from the page is the return path. The block answers it the way a cache holding a modified copy of the line would. It raises a snoop hit-modified indication a fixed number of cycles after the address phase. It then drives a whole 32-byte line as four 64-bit beats in critical-word-first order. Memory observes the same beats as the requester, so both see one consistent line. A read that comes before any argument write returns an all-zero line and raises a sticky error flag. Three counters record page reads, page writes and cache-to-cache responses.

A small sequencer drives the response, with four states. `S_IDLE` waits for a page read. An accepted read moves it to `S_WAIT`, or straight to `S_HIT` when the snoop delay is one. `S_WAIT` counts out the snoop delay and then moves to `S_HIT`. `S_HIT` asserts the hit-modified strobe for one cycle and always moves to `S_XFER`. `S_XFER` drives the four beats and returns to `S_IDLE` after the fourth.

Top module: `snoop_mailbox`

## Requirements
- R1: Only transactions with `bus_addr[31:12] == page_base` are claimed. Any other transaction raises no hit, no data beats, no counter change and no change of the stored argument.
- R2: A page write stores `arg = bus_addr[11:0]` and the result `lat = 4 + 3*arg[3:0] + arg[11:4]` (16 bits).
- R3: A page read accepted in cycle c asserts `snoop_hitm` for exactly one cycle, cycle c+SNOOP_DELAY (default 2).
- R4: `rsp_valid` is high in cycles c+SNOOP_DELAY+1 through c+SNOOP_DELAY+4. Beat i (i = 0..3) carries line word `(bus_addr[4:3] + i) mod 4`. `rsp_data` is zero outside beats.
- R5: In the line, word 0 is `{36'b0, arg, lat}`, with lat in bits 15:0 and arg in bits 27:16. Word k (k = 1..3) holds k in bits 63:62 and zeros in every other bit.
- R6: A page read before any page write since reset returns four all-zero beats and sets `err_sticky`, which stays set until reset.
- R7: The line content is fixed at the read's address phase. A page write during the beats changes only the lines of later reads.
- R8: A page read arriving while a response is in progress gets no hit and no beats, but is still counted in `cnt_reads`.
- R9: `cnt_reads`, `cnt_writes` and `cnt_c2c` count page reads, page writes and issued hit-modified responses, each by one per event.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_base | input | 20 | Upper address bits of the communication page |
| bus_valid | input | 1 | Address phase strobe, one transaction per cycle |
| bus_write | input | 1 | 1 = write (host to block), 0 = read (block to host) |
| bus_addr | input | 32 | Transaction byte address |
| snoop_hitm | output | 1 | Hit-modified snoop result |
| rsp_valid | output | 1 | Data beat valid |
| rsp_data | output | 64 | Data beat |
| err_sticky | output | 1 | Set by a read before any argument |
| cnt_reads | output | 16 | Page reads seen |
| cnt_writes | output | 16 | Page writes seen |
| cnt_c2c | output | 16 | Cache-to-cache responses issued |

## Verification
The main function is driven with arguments that fill different fields of the lookup: zero, all ones, values that change only the table index, and values that change only the added upper byte. A wrong table step or a wrong field split therefore shows up as a wrong latency. Reads use all four critical-word offsets, so a beat order that is rotated or reversed gives a mismatch on at least one of them. Further reads are placed before any write, in a foreign page, and during a response in progress, with a page write during the beats. These separate a correct decode and line snapshot from designs that answer foreign addresses, rebuild the line late, or accept overlapping reads.

// File: rtl/snpmbx_pkg.sv
package snpmbx_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_HIT,
        S_XFER
    } seq_state_t;

    localparam int LINE_WORDS = 4;
    localparam int LUT_DEPTH  = 16;
endpackage

// File: rtl/snpmbx_decode.sv
module snpmbx_decode #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int OFF_W  = 12
) (
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [ADDR_W-OFF_W-1:0] page_base,
    output logic                    pg_wr,
    output logic                    pg_rd,
    output logic [OFF_W-1:0]        arg,
    output logic [1:0]              crit
);
    localparam int BEAT_LSB = $clog2(DATA_W / 8);

    logic in_page;

    always_comb begin
        in_page = bus_valid && (bus_addr[ADDR_W-1:OFF_W] == page_base);
        pg_wr   = in_page && bus_write;
        pg_rd   = in_page && !bus_write;
        arg     = bus_addr[OFF_W-1:0];
        crit    = bus_addr[BEAT_LSB+1:BEAT_LSB];
    end
endmodule

// File: rtl/snpmbx_func.sv
module snpmbx_func #(
    parameter int OFF_W    = 12,
    parameter int LAT_W    = 16,
    parameter int LUT_BASE = 4,
    parameter int LUT_STEP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pg_wr,
    input  logic [OFF_W-1:0] arg,
    output logic [OFF_W-1:0] arg_q,
    output logic [LAT_W-1:0] lat_q,
    output logic             have_arg
);
    import snpmbx_pkg::*;

    localparam int IDX_W = $clog2(LUT_DEPTH);

    logic [LAT_W-1:0] lut [LUT_DEPTH];
    logic [LAT_W-1:0] lat_d;

    for (genvar i = 0; i < LUT_DEPTH; i++) begin : g_lut
        assign lut[i] = LAT_W'(LUT_BASE + LUT_STEP * i);
    end

    always_comb begin
        lat_d = lut[arg[IDX_W-1:0]] + LAT_W'(arg[OFF_W-1:IDX_W]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q    <= '0;
            lat_q    <= '0;
            have_arg <= 1'b0;
        end else if (pg_wr) begin
            arg_q    <= arg;
            lat_q    <= lat_d;
            have_arg <= 1'b1;
        end
    end

    // R2: the stored result always follows the most recent argument
    a_r2_result_tracks_write: assert property (@(posedge clk) disable iff (!rst_n)
        pg_wr |=> (arg_q == $past(arg)));
endmodule

// File: rtl/snpmbx_seq.sv
module snpmbx_seq #(
    parameter int DATA_W      = 64,
    parameter int OFF_W       = 12,
    parameter int LAT_W       = 16,
    parameter int SNOOP_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_rd,
    input  logic [1:0]        crit,
    input  logic [OFF_W-1:0]  arg_q,
    input  logic [LAT_W-1:0]  lat_q,
    input  logic              have_arg,
    output logic              hitm,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              err_sticky
);
    import snpmbx_pkg::*;

    localparam int DLY_W = $clog2(SNOOP_DELAY + 1);

    seq_state_t        st_q, st_d;
    logic [DLY_W-1:0]  dly_q;
    logic [1:0]        beat_q;
    logic [1:0]        crit_q;
    logic [DATA_W-1:0] line_q [LINE_WORDS];
    logic [DATA_W-1:0] line_d [LINE_WORDS];
    logic              accept;

    assign accept = pg_rd && (st_q == S_IDLE);

    // line image built from the held result
    always_comb begin
        for (int k = 0; k < LINE_WORDS; k++) begin
            if (!have_arg) begin
                line_d[k] = '0;
            end else if (k == 0) begin
                line_d[k] = DATA_W'({arg_q, lat_q});
            end else begin
                line_d[k] = {2'(k), {(DATA_W-2){1'b0}}};
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (pg_rd) st_d = (SNOOP_DELAY == 1) ? S_HIT : S_WAIT;
            S_WAIT: if (dly_q == DLY_W'(SNOOP_DELAY - 1)) st_d = S_HIT;
            S_HIT:  st_d = S_XFER;
            S_XFER: if (beat_q == 2'd3) st_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q      <= '0;
            beat_q     <= '0;
            crit_q     <= '0;
            err_sticky <= 1'b0;
            for (int k = 0; k < LINE_WORDS; k++) line_q[k] <= '0;
        end else begin
            if (accept) begin
                dly_q  <= DLY_W'(1);
                crit_q <= crit;
                for (int k = 0; k < LINE_WORDS; k++) line_q[k] <= line_d[k];
                if (!have_arg) err_sticky <= 1'b1;
            end else if (st_q == S_WAIT) begin
                dly_q <= dly_q + DLY_W'(1);
            end
            if (st_q == S_HIT) begin
                beat_q <= '0;
            end else if (st_q == S_XFER) begin
                beat_q <= beat_q + 2'd1;
            end
        end
    end

    // outputs
    always_comb begin
        hitm      = (st_q == S_HIT);
        rsp_valid = (st_q == S_XFER);
        rsp_data  = rsp_valid ? line_q[crit_q + beat_q] : '0;
    end

    // R3: the hit-modified strobe lasts exactly one cycle
    a_r3_hitm_single: assert property (@(posedge clk) disable iff (!rst_n)
        hitm |=> !hitm);
    // R4: data beats start right after the strobe
    a_r4_beats_follow_hitm: assert property (@(posedge clk) disable iff (!rst_n)
        hitm |=> rsp_valid);
    // R7: line content does not move while beats are driven
    a_r7_line_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rsp_valid)) |-> $stable(line_q[0]));
    // R6: error flag never clears outside reset
    a_r6_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);
endmodule

// File: rtl/snpmbx_stats.sv
module snpmbx_stats #(
    parameter int CNT_W = 16,
    parameter int N_CNT = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CNT-1:0]            inc,
    output logic [N_CNT-1:0][CNT_W-1:0] cnt
);
    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt[i] <= '0;
            end else if (inc[i]) begin
                cnt[i] <= cnt[i] + CNT_W'(1);
            end
        end

        // R9: a counter only ever steps by one
        a_r9_step_one: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[i] != $past(cnt[i])) |-> (cnt[i] == $past(cnt[i]) + CNT_W'(1)));
    end
endmodule

// File: rtl/snoop_mailbox.sv
module snoop_mailbox #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int OFF_W       = 12,
    parameter int LAT_W       = 16,
    parameter int CNT_W       = 16,
    parameter int SNOOP_DELAY = 2,
    parameter int LUT_BASE    = 4,
    parameter int LUT_STEP    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-OFF_W-1:0] page_base,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    output logic                    snoop_hitm,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_data,
    output logic                    err_sticky,
    output logic [CNT_W-1:0]        cnt_reads,
    output logic [CNT_W-1:0]        cnt_writes,
    output logic [CNT_W-1:0]        cnt_c2c
);
    logic             pg_wr, pg_rd;
    logic [OFF_W-1:0] arg, arg_q;
    logic [1:0]       crit;
    logic [LAT_W-1:0] lat_q;
    logic             have_arg;
    logic [2:0][CNT_W-1:0] cnt;

    snpmbx_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .page_base (page_base),
        .pg_wr     (pg_wr),
        .pg_rd     (pg_rd),
        .arg       (arg),
        .crit      (crit)
    );

    snpmbx_func #(.OFF_W(OFF_W), .LAT_W(LAT_W), .LUT_BASE(LUT_BASE),
                  .LUT_STEP(LUT_STEP)) u_func (
        .clk      (clk),
        .rst_n    (rst_n),
        .pg_wr    (pg_wr),
        .arg      (arg),
        .arg_q    (arg_q),
        .lat_q    (lat_q),
        .have_arg (have_arg)
    );

    snpmbx_seq #(.DATA_W(DATA_W), .OFF_W(OFF_W), .LAT_W(LAT_W),
                 .SNOOP_DELAY(SNOOP_DELAY)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pg_rd      (pg_rd),
        .crit       (crit),
        .arg_q      (arg_q),
        .lat_q      (lat_q),
        .have_arg   (have_arg),
        .hitm       (snoop_hitm),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .err_sticky (err_sticky)
    );

    snpmbx_stats #(.CNT_W(CNT_W), .N_CNT(3)) u_stats (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   ({snoop_hitm, pg_wr, pg_rd}),
        .cnt   (cnt)
    );

    assign cnt_reads  = cnt[0];
    assign cnt_writes = cnt[1];
    assign cnt_c2c    = cnt[2];

    // R4: strobe and beats never overlap
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(snoop_hitm && rsp_valid));
    // R1: a foreign-page read never starts a response
    a_r1_foreign_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_addr[ADDR_W-1:OFF_W] != page_base) && !rsp_valid
         && !snoop_hitm && $past(!snoop_hitm) && $past(!rsp_valid)) |=> !snoop_hitm);
endmodule

// File: tb/snoop_mailbox_test.sv
`timescale 1ns/1ps
module snoop_mailbox_test;
    localparam int D = 2;
    localparam logic [19:0] PB = 20'hC0FFE;
    localparam int NV = 12;
    // bit 12 = write, bits 11:0 = page offset
    localparam logic [12:0] VEC [NV] = '{
        13'h1123, 13'h0000, 13'h0018, 13'h1FFF, 13'h0008, 13'h1000,
        13'h0010, 13'h1A5C, 13'h0FF8, 13'h107F, 13'h03F0, 13'h0FE8
    };

    logic        clk = 0, rst_n = 0;
    logic [19:0] page_base = PB;
    logic        bus_valid = 0, bus_write = 0;
    logic [31:0] bus_addr = '0;
    logic        snoop_hitm, rsp_valid, err_sticky;
    logic [63:0] rsp_data;
    logic [15:0] cnt_reads, cnt_writes, cnt_c2c;

    int n_chk = 0, n_fail = 0;
    logic [11:0] m_arg = '0;
    bit          m_have = 0;
    int          e_rd = 0, e_wr = 0, e_c2c = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    snoop_mailbox #(.SNOOP_DELAY(D)) uut (
        .clk(clk), .rst_n(rst_n), .page_base(page_base), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .snoop_hitm(snoop_hitm),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err_sticky(err_sticky),
        .cnt_reads(cnt_reads), .cnt_writes(cnt_writes), .cnt_c2c(cnt_c2c)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lat_of(input logic [11:0] a);
        return 16'(4 + 3 * int'(a[3:0]) + int'(a[11:4]));
    endfunction

    function automatic logic [63:0] word_of(input int k, input logic [11:0] a, input bit v);
        if (!v) return '0;
        if (k == 0) return {36'b0, a, lat_of(a)};
        return {2'(k), 62'b0};
    endfunction

    task automatic do_write(input logic [19:0] pg, input logic [11:0] off);
        bus_valid = 1; bus_write = 1; bus_addr = {pg, off};
        @(negedge clk);
        bus_valid = 0;
        if (pg == PB) begin m_arg = off; m_have = 1; e_wr++; end
    endtask

    // page read with optional injected transaction during the first beat
    task automatic do_read(input logic [11:0] off, input bit inj, input bit inj_wr,
                           input logic [11:0] inj_off, input string tag);
        logic [11:0] a = m_arg;
        bit          v = m_have;
        int          c = int'(off[4:3]);
        bus_valid = 1; bus_write = 0; bus_addr = {PB, off};
        e_rd++; e_c2c++;
        for (int k = 1; k <= D + 6; k++) begin
            @(negedge clk);
            if (k == 1 || k == D + 2) bus_valid = 0;
            chk({tag, " R3 hitm"}, 64'(snoop_hitm), 64'(k == D));
            chk({tag, " R4 valid"}, 64'(rsp_valid), 64'(k > D && k <= D + 4));
            chk({tag, " R4/R5 data"}, rsp_data,
                (k > D && k <= D + 4) ? word_of((c + k - D - 1) % 4, a, v) : 64'b0);
            if (inj && k == D + 1) begin
                bus_valid = 1; bus_write = inj_wr; bus_addr = {PB, inj_off};
                if (inj_wr) begin m_arg = inj_off; m_have = 1; e_wr++; end
                else e_rd++;
            end
        end
    endtask

    task automatic chk_counts(input string tag);
        chk({tag, " R9 reads"}, 64'(cnt_reads), 64'(e_rd));
        chk({tag, " R9 writes"}, 64'(cnt_writes), 64'(e_wr));
        chk({tag, " R9 c2c"}, 64'(cnt_c2c), 64'(e_c2c));
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 hitm", 64'(snoop_hitm), 0);
        chk("R10 valid", 64'(rsp_valid), 0);
        chk("R10 data", rsp_data, 0);
        chk("R10 err", 64'(err_sticky), 0);
        chk_counts("R10");
        rst_n = 1;
        @(negedge clk);

        // R6: read before any argument
        do_read(12'h008, 0, 0, 0, "R6 early");
        chk("R6 err set", 64'(err_sticky), 1);

        // R2/R4/R5 table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][12]) do_write(PB, VEC[i][11:0]);
            else do_read(VEC[i][11:0], 0, 0, 0, "R2 table");
        end
        chk_counts("R9 table");

        // R1: foreign read and write
        bus_valid = 1; bus_write = 0; bus_addr = {PB ^ 20'h1, 12'h008};
        for (int k = 1; k <= D + 5; k++) begin
            @(negedge clk);
            bus_valid = 0;
            chk("R1 foreign hitm", 64'(snoop_hitm), 0);
            chk("R1 foreign valid", 64'(rsp_valid), 0);
        end
        do_write(PB ^ 20'h1, 12'h555);
        chk_counts("R1 counts");
        do_read(12'h000, 0, 0, 0, "R1 arg kept");

        // R7: write during beats
        do_read(12'h010, 1, 1, 12'h2B4, "R7 frozen");
        do_read(12'h018, 0, 0, 0, "R7 later");

        // R8: read during beats
        do_read(12'h008, 1, 0, 12'h000, "R8 busy");
        chk_counts("R8 counts");
        chk("R6 err held", 64'(err_sticky), 1);

        // R10: second reset
        rst_n = 0;
        @(negedge clk);
        e_rd = 0; e_wr = 0; e_c2c = 0;
        chk("R10 err cleared", 64'(err_sticky), 0);
        chk_counts("R10 again");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule